// File: doc/BRIEF.md
# PHY Register Handshake Access Sequencer

This block carries single read and write accesses into a 16-bit register space inside a PHY. That space is not memory mapped. It is reached through a control word that the block drives and a status word that the block samples. The PHY answers each step of an access with an acknowledge bit. Every step is a four-phase exchange: the block presents a value with one strobe bit set, waits for the acknowledge to go high, removes the strobe, and waits for the acknowledge to go low.

The local side issues one request at a time. A request carries an address, write data and a write flag. When the access finishes, the block returns a one-cycle done pulse and, for a read, the sampled data. If the PHY stops answering, it returns a one-cycle error pulse instead. The block checks the acknowledge at a fixed interval that a prescaler sets, and it gives up after a bounded number of checks. A hung PHY therefore never stalls the requester for long.

Top module: `phy_hs_master`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o` and `err_o` are 0, the control word is all zero and `rdata_o` is 0.
- R2: The control word carries the value in bits 15:0. Bit 16 captures an address, bit 17 captures data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is set at any time. The status word carries read data in bits 15:0 and the acknowledge in bit 16.
- R3: Every access starts with an address phase. The control word is the address alone, then the address with bit 16, then the address alone again. The step after the address with bit 16 waits for acknowledge high, and the step after that waits for acknowledge low.
- R4: A write then presents the data alone, then the data with bit 17 (wait high), then the data alone (wait low). Next comes bit 18 alone (wait high), then the data alone (wait low), and then zero. After the zero step the block raises done and goes idle.
- R5: A read, after its address phase, presents bit 19 alone and waits for acknowledge high. On that acknowledge it samples status bits 15:0 into `rdata_o`. It then drives zero, waits for acknowledge low, and raises done.
- R6: In each wait, the block checks the acknowledge in the first cycle of the step and then every POLL_GAP cycles, at most MAX_POLLS times. The step ends in the cycle after the first check that sees the expected level. An acknowledge seen on the last allowed check still succeeds.
- R7: If the last allowed check fails, the access aborts. `err_o` pulses for one cycle with no done, the control word is zero in that cycle, and the block is idle and accepts a new request.
- R8: A request is accepted only when `busy_o` is 0. A request raised while busy has no effect on the running access and starts no later access.
- R9: `rdata_o` changes only when a read samples its data. Writes and aborted reads leave it unchanged.
- R10: `busy_o` rises in the cycle after acceptance and falls in the cycle where `done_o` or `err_o` pulses. `done_o` and `err_o` are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request access (taken when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| rdata_o | output | 16 | Last successfully read data |
| phy_ctrl_o | output | 20 | Control word to the PHY |
| phy_stat_i | input | 17 | Status word from the PHY |

## Verification
A wrong step state shows up at once as a control word value out of order. The bench records every change of the control word during an access and compares the whole trace with the expected list. A broken prescaler or poll counter shows up as a change in the cycle count from request to done. With ack delays up to nine poll gaps, that count is off by at least one gap, and the bench checks it exactly. A wrong abort path shows up as a done instead of an error, as a nonzero control word, or as read data that changes when it should hold. All of these appear within the access that caused them.

// File: rtl/phy_hs_pkg.sv
package phy_hs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_A_SET  = 4'd1,
    ST_A_CAP  = 4'd2,
    ST_A_REL  = 4'd3,
    ST_D_SET  = 4'd4,
    ST_D_CAP  = 4'd5,
    ST_D_REL  = 4'd6,
    ST_WR_STB = 4'd7,
    ST_WR_REL = 4'd8,
    ST_W_CLR  = 4'd9,
    ST_RD_STB = 4'd10,
    ST_RD_REL = 4'd11
  } step_e;

  // True for steps that wait on the acknowledge
  function automatic logic step_waits(step_e s);
    case (s)
      ST_A_CAP, ST_A_REL, ST_D_CAP, ST_D_REL,
      ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Acknowledge level a waiting step expects
  function automatic logic step_ack_level(step_e s);
    case (s)
      ST_A_CAP, ST_D_CAP, ST_WR_STB, ST_RD_STB: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Successor of a step on a normal exit
  function automatic step_e step_next(step_e s, logic is_wr);
    case (s)
      ST_IDLE:   return ST_A_SET;
      ST_A_SET:  return ST_A_CAP;
      ST_A_CAP:  return ST_A_REL;
      ST_A_REL:  return is_wr ? ST_D_SET : ST_RD_STB;
      ST_D_SET:  return ST_D_CAP;
      ST_D_CAP:  return ST_D_REL;
      ST_D_REL:  return ST_WR_STB;
      ST_WR_STB: return ST_WR_REL;
      ST_WR_REL: return ST_W_CLR;
      ST_RD_STB: return ST_RD_REL;
      default:   return ST_IDLE;
    endcase
  endfunction

  // Strobe field of the control word (bit0 cap-addr .. bit3 read)
  function automatic logic [3:0] step_strobes(step_e s);
    case (s)
      ST_A_CAP:  return 4'b0001;
      ST_D_CAP:  return 4'b0010;
      ST_WR_STB: return 4'b0100;
      ST_RD_STB: return 4'b1000;
      default:   return 4'b0000;
    endcase
  endfunction

  // Which latched value the low field of the control word carries
  typedef enum logic [1:0] {VAL_ZERO, VAL_ADDR, VAL_DATA} val_sel_e;

  function automatic val_sel_e step_value(step_e s);
    case (s)
      ST_A_SET, ST_A_CAP, ST_A_REL:           return VAL_ADDR;
      ST_D_SET, ST_D_CAP, ST_D_REL, ST_WR_REL: return VAL_DATA;
      default:                                 return VAL_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/phy_hs_poll.sv
module phy_hs_poll #(
  parameter int POLL_GAP  = 250,
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  output logic check_now,
  output logic final_poll
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam logic [GW-1:0] GAP_LAST  = GW'(POLL_GAP - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;

  assign check_now  = active && (gap_cnt == '0);
  assign final_poll = (poll_cnt == POLL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      gap_cnt  <= '0;
      poll_cnt <= '0;
    end else if (active) begin
      gap_cnt <= (gap_cnt == GAP_LAST) ? '0 : gap_cnt + 1'b1;
      if (check_now && !final_poll) poll_cnt <= poll_cnt + 1'b1;
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PW'(MAX_POLLS)); // R6

endmodule

// File: rtl/phy_hs_seq.sv
module phy_hs_seq
  import phy_hs_pkg::*;
#(
  parameter int POLL_GAP  = 250,
  parameter int MAX_POLLS = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  is_wr,
  input  logic  ack,
  output step_e step_q,
  output logic  rd_sample,
  output logic  done_q,
  output logic  err_q
);
  logic  waits, check_now, final_poll, matched, fail, leave;
  step_e step_d;

  assign waits   = step_waits(step_q);
  assign matched = check_now && (ack == step_ack_level(step_q));
  assign fail    = check_now && !matched && final_poll;

  always_comb begin
    step_d = step_q;
    if (step_q == ST_IDLE) begin
      if (start) step_d = ST_A_SET;
    end else if (!waits) begin
      step_d = step_next(step_q, is_wr);
    end else if (matched) begin
      step_d = step_next(step_q, is_wr);
    end else if (fail) begin
      step_d = ST_IDLE;
    end
  end

  assign leave     = (step_d != step_q);
  assign rd_sample = (step_q == ST_RD_STB) && matched;

  phy_hs_poll #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .active(waits), .restart(leave),
    .check_now(check_now), .final_poll(final_poll)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= (step_q == ST_W_CLR) || ((step_q == ST_RD_REL) && matched);
      err_q  <= fail;
    end
  end

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q); // R7

endmodule

// File: rtl/phy_hs_master.sv
module phy_hs_master
  import phy_hs_pkg::*;
#(
  parameter int W         = 16,
  parameter int POLL_GAP  = 250,
  parameter int MAX_POLLS = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic           wr_i,
  input  logic [W-1:0]   addr_i,
  input  logic [W-1:0]   wdata_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [W-1:0]   rdata_o,
  output logic [W+3:0]   phy_ctrl_o,
  input  logic [W:0]     phy_stat_i
);
  localparam int ACK_BIT = W;

  step_e        step_q;
  logic         accept, rd_sample, ack;
  logic         wr_q;
  logic [W-1:0] addr_q, data_q, rdata_q;

  function automatic logic [W+3:0] ctrl_word(step_e s, logic [W-1:0] a, logic [W-1:0] d);
    logic [W-1:0] v;
    case (step_value(s))
      VAL_ADDR: v = a;
      VAL_DATA: v = d;
      default:  v = '0;
    endcase
    return {step_strobes(s), v};
  endfunction

  assign ack    = phy_stat_i[ACK_BIT];
  assign accept = req_i && (step_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      wr_q   <= wr_i;
      addr_q <= addr_i;
      data_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_sample) rdata_q <= phy_stat_i[W-1:0];
  end

  phy_hs_seq #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .is_wr(wr_q), .ack(ack),
    .step_q(step_q), .rd_sample(rd_sample), .done_q(done_o), .err_q(err_o)
  );

  assign busy_o     = (step_q != ST_IDLE);
  assign rdata_o    = rdata_q;
  assign phy_ctrl_o = ctrl_word(step_q, addr_q, data_q);

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl_o[W+3:W])); // R2
  AST_ERR_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (phy_ctrl_o == '0) && !busy_o); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_i) |=> $stable(addr_q) && $stable(data_q)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != ST_RD_STB) |=> $stable(rdata_o)); // R9
  AST_WAIT_EXIT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (step_waits(step_q) && $past(step_q) != step_q && step_waits($past(step_q))
     && !err_o) |-> $past(ack) == step_ack_level($past(step_q))); // R6
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R10

endmodule

// File: tb/phy_hs_master_tb.sv
module phy_hs_master_tb;
  localparam int G = 8;
  localparam int MAXP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic busy, done, err;
  logic [15:0] rdata;
  logic [19:0] ctrl;
  logic [16:0] stat;

  always #2 clk = ~clk; // 250 MHz

  phy_hs_master #(.W(16), .POLL_GAP(G), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .phy_ctrl_o(ctrl), .phy_stat_i(stat)
  );

  // ---------------- PHY responder model ----------------
  int base_dly = 1, rd_dly = 1;
  int hi_cnt = 0, lo_cnt = 0;
  logic ack_m = 1'b0;
  logic [15:0] cap_a = '0, cap_d = '0;
  logic [15:0] mem [16];
  logic [15:0] shadow [16];

  assign stat = {ack_m, mem[cap_a[3:0]]};

  always @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt = 0; lo_cnt = 0; ack_m <= 1'b0;
    end else begin
      if (ctrl[19:16] != 4'b0) begin
        lo_cnt = 0; hi_cnt = hi_cnt + 1;
        if (hi_cnt >= (ctrl[19] ? rd_dly : base_dly)) ack_m <= 1'b1;
      end else begin
        hi_cnt = 0; lo_cnt = lo_cnt + 1;
        if (lo_cnt >= base_dly) ack_m <= 1'b0;
      end
      if (ctrl[16]) cap_a <= ctrl[15:0];
      if (ctrl[17]) cap_d <= ctrl[15:0];
      if (ctrl[18]) mem[cap_a[3:0]] <= cap_d;
    end
  end

  // ---------------- control word trace ----------------
  logic [19:0] trace [20];
  int tn = 0;
  logic [19:0] prev_ctrl = '0;
  always @(negedge clk) begin
    if (ctrl != prev_ctrl && tn < 20) begin
      trace[tn] = ctrl; tn = tn + 1;
    end
    prev_ctrl = ctrl;
  end

  logic [19:0] expv [20];
  int en;

  task automatic exp_push(input logic [19:0] v);
    if (en == 0 ? (v != 20'h0) : (v != expv[en-1])) begin
      expv[en] = v; en = en + 1;
    end
  endtask

  task automatic build_exp(input bit w, input logic [15:0] a, input logic [15:0] d);
    en = 0;
    exp_push({4'h0, a}); exp_push({4'h1, a}); exp_push({4'h0, a});
    if (w) begin
      exp_push({4'h0, d}); exp_push({4'h2, d}); exp_push({4'h0, d});
      exp_push({4'h4, 16'h0}); exp_push({4'h0, d}); exp_push(20'h0);
    end else begin
      exp_push({4'h8, 16'h0}); exp_push(20'h0);
    end
  endtask

  // ---------------- expectations ----------------
  function automatic int wlen(input int d);
    return ((d + G - 1) / G) * G + 1;
  endfunction
  function automatic int exp_lat(input bit w, input int d);
    return w ? 4 + 6 * wlen(d) : 2 + 4 * wlen(d);
  endfunction
  function automatic logic [15:0] init_val(input int i);
    return 16'h5A00 ^ 16'(i * 37);
  endfunction

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] expct);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req_tag, what, act, expct);
    end
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [15:0] d,
                        output int cyc, output bit got_done, output bit got_err);
    @(negedge clk);
    tn = 0;
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    cyc = 1;
    got_done = done; got_err = err;
    while (!got_done && !got_err && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      got_done = done; got_err = err;
    end
  endtask

  task automatic run_ok(input bit w, input logic [15:0] a, input logic [15:0] d,
                        input int dly, input string tag);
    int cyc; bit gd, ge;
    base_dly = dly; rd_dly = dly;
    access(w, a, d, cyc, gd, ge);
    check(gd && !ge && !busy, "R10", {tag, " done without error"}, {gd, ge, busy}, 3'b100);
    check(cyc == exp_lat(w, dly), "R6", {tag, " latency"}, cyc, exp_lat(w, dly));
    check(ctrl == 20'h0, w ? "R4" : "R5", {tag, " control word cleared"}, ctrl, 0);
    build_exp(w, a, d);
    begin
      bit same = (tn == en);
      for (int i = 0; i < en && same; i++) if (trace[i] != expv[i]) same = 1'b0;
      check(same, w ? "R4" : "R3", {tag, " control trace"}, tn, en);
    end
    if (w) begin
      shadow[a[3:0]] = d;
      check(mem[a[3:0]] == d, "R4", {tag, " PHY register written"}, mem[a[3:0]], d);
    end else begin
      check(rdata == shadow[a[3:0]], "R5", {tag, " read data"}, rdata, shadow[a[3:0]]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc; bit gd, ge;
    logic [15:0] held;
    void'($urandom(32'h2bad_5eed));
    for (int i = 0; i < 16; i++) begin mem[i] = init_val(i); shadow[i] = init_val(i); end
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "R1", "reset flags", {busy, done, err}, 0);
    check(ctrl == 20'h0, "R1", "reset control word", ctrl, 0);
    check(rdata == 16'h0, "R1", "reset read data", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && ctrl == 20'h0, "R1", "idle after reset release", {busy, ctrl}, 0);

    // directed: zero address and data equal to address (trace collapsing)
    run_ok(1'b1, 16'h0000, 16'h1234, 1, "R4 write addr0");
    run_ok(1'b0, 16'h0000, 16'h0, 1, "R5 read addr0");
    run_ok(1'b1, 16'h0007, 16'h0007, 3, "R3 write data=addr");
    // R6: ack on the last allowed poll still succeeds
    run_ok(1'b1, 16'h0002, 16'hBEEF, (MAXP - 1) * G, "R6 last poll write");
    run_ok(1'b0, 16'h0002, 16'h0, (MAXP - 1) * G, "R6 last poll read");

    // random mix
    for (int k = 0; k < 40; k++) begin
      bit w = $urandom_range(1, 0) == 1;
      logic [15:0] a = 16'($urandom);
      logic [15:0] d = 16'($urandom);
      int dly = $urandom_range((MAXP - 1) * G, 1);
      run_ok(w, a, d, dly, w ? "R4 random write" : "R5 random read");
    end

    // R7: ack one cycle too late on the first wait -> timeout
    held = rdata;
    base_dly = (MAXP - 1) * G + 1; rd_dly = base_dly;
    access(1'b0, 16'h0003, 16'h0, cyc, gd, ge);
    check(ge && !gd, "R7", "address wait timeout flags", {gd, ge}, 2'b01);
    check(cyc == (MAXP - 1) * G + 3, "R7", "timeout latency", cyc, (MAXP - 1) * G + 3);
    check(ctrl == 20'h0 && !busy, "R7", "control zero and idle at error", {busy, ctrl}, 0);
    check(rdata == held, "R9", "read data held after failed read", rdata, held);
    @(negedge clk);
    check(!err && !done, "R10", "error is a single pulse", {done, err}, 0);

    // R7 + R9: read strobe never acknowledged
    base_dly = 1; rd_dly = (MAXP - 1) * G + 1;
    access(1'b0, 16'h0005, 16'h0, cyc, gd, ge);
    check(ge && !gd, "R7", "read strobe timeout", {gd, ge}, 2'b01);
    check(cyc == 1 + 2 * wlen(1) + (MAXP - 1) * G + 2, "R7", "read timeout latency",
          cyc, 1 + 2 * wlen(1) + (MAXP - 1) * G + 2);
    check(rdata == held, "R9", "read data held after read abort", rdata, held);

    // recovery after error
    run_ok(1'b0, 16'h0005, 16'h0, 2, "R7 recovery read");
    held = rdata;
    run_ok(1'b1, 16'h0006, 16'hCAFE, 2, "R9 write");
    check(rdata == held, "R9", "read data held over write", rdata, held);

    // R8: request while busy is ignored
    base_dly = 2; rd_dly = 2;
    @(negedge clk);
    tn = 0;
    req = 1'b1; wr = 1'b1; addr = 16'h0009; wdata = 16'h1111;
    @(negedge clk);
    req = 1'b0;
    repeat (4) @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = 16'h000A; wdata = 16'h2222;
    @(negedge clk);
    req = 1'b0;
    cyc = 0;
    while (!done && !err && cyc < 4000) begin @(negedge clk); cyc++; end
    check(done, "R8", "first access completes", done, 1);
    build_exp(1'b1, 16'h0009, 16'h1111);
    begin
      bit same = (tn == en);
      for (int i = 0; i < en && same; i++) if (trace[i] != expv[i]) same = 1'b0;
      check(same, "R8", "trace unaffected by busy request", tn, en);
    end
    shadow[9] = 16'h1111;
    repeat (6) @(negedge clk);
    check(!busy && ctrl == 20'h0, "R8", "no access started from busy request", {busy, ctrl}, 0);
    check(mem[10] == shadow[10], "R8", "ignored target untouched", mem[10], shadow[10]);
    check(mem[9] == 16'h1111, "R8", "first write landed", mem[9], 16'h1111);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule